// File: doc/BRIEF.md
# Base Integer Instruction Decoder

This block turns one 32-bit instruction word of the base integer instruction set into the control bundle that a pipeline's later stages consume. The bundle holds the register indices, a 32-bit immediate that is already extended, an ALU operation code, the memory access kind with its size and signedness, a branch or jump kind, and a class for ordering and system instructions. Trap logic can act on that class later without decoding the word again.

The block is pure combinational logic, with no clock and no state. Every word is either accepted or flagged as illegal. An illegal word drives a bundle in which nothing can take effect: no register write, no memory access, no control transfer and no system class. Compressed encodings, extension opcodes and privileged system words other than the environment call and the breakpoint all count as illegal.

Top module: `inst_decoder`

## Requirements
- R1: The outputs depend only on `inst` and follow it with no clock edge in between.
- R2: A word is illegal, and `illegal` is 1, when `inst[1:0]` is not 11 or when `inst[6:0]` is none of these opcodes: 0110111 (upper immediate load), 0010111 (add upper immediate to pc), 1101111 (jump and link), 1100111 (jump and link register), 1100011 (conditional branch), 0000011 (load), 0100011 (store), 0010011 (register-immediate arithmetic), 0110011 (register-register arithmetic), 0001111 (ordering) and 1110011 (system).
- R3: When `illegal` is 1, `rd_we`, `mem_rd` and `mem_wr` are 0 and `rd_idx`, `rs1_idx`, `rs2_idx`, `imm`, `alu_op`, `mem_size`, `mem_unsigned`, `br_type` and `sys_class` are all 0.
- R4: Signed immediates are sign-extended from `inst[31]`. The I form takes inst[31:20]. The S form takes {inst[31:25], inst[11:7]}. The B form takes {inst[31], inst[7], inst[30:25], inst[11:8], 0}. The J form takes {inst[31], inst[19:12], inst[20], inst[30:21], 0}. The U form is {inst[31:12], 12 zero bits}. Register-register words give 0, and so do the ordering words, the environment call and the breakpoint.
- R5: Immediate shifts give the 5-bit shift amount inst[24:20], zero-extended. CSR words give the 12-bit CSR number inst[31:20], zero-extended.
- R6: `rd_idx` is inst[11:7] when `rd_we` is 1 and 0 otherwise. `rs1_idx` is inst[19:15] for jump and link register, branch, load, store, both arithmetic families and the CSR register forms (funct3 001, 010, 011), and 0 otherwise. `rs2_idx` is inst[24:20] for branch, store and register-register arithmetic, and 0 otherwise.
- R7: The `alu_op` codes are ADD 0, SUB 1, SLL 2, SLT 3, SLTU 4, XOR 5, SRL 6, SRA 7, OR 8, AND 9 and PASS-immediate 10. Both arithmetic families select the code from funct3 (000 add/sub, 001 sll, 010 slt, 011 sltu, 100 xor, 101 srl/sra, 110 or, 111 and). Upper immediate load gives 10. Every other legal word gives 0.
- R8: Loads set `mem_rd` and stores set `mem_wr`. `mem_size` = funct3[1:0] (0 byte, 1 half, 2 word). `mem_unsigned` = funct3[2] for loads and 0 for stores.
- R9: `br_type` codes are none 0, eq 1, ne 2, lt 3, ge 4, ltu 5, geu 6, jal 7 and jalr 8, with branch funct3 000, 001, 100, 101, 110, 111 mapping to 1 to 6. The jump and link register immediate is passed unchanged, with its low bit not cleared.
- R10: These are illegal: jump and link register with funct3 other than 000; branch funct3 010 or 011; load funct3 011, 110 or 111; store funct3 011 or above; an immediate shift whose funct7 is not 0000000 (or not 0100000 for the right shift, funct3 101); a register-register funct7 other than 0000000, or 0100000 with funct3 other than 000 and 101; ordering funct3 other than 000 and 001; system funct3 100.
- R11: `rd_we` is 1 only for legal upper immediate, add-upper-to-pc, both jump, load, both arithmetic and CSR words.
- R12: `sys_class` codes are none 0, fence 1, instruction fence 2, CSR 3, environment call 4 and breakpoint 5. The environment call is exactly 0x00000073, the breakpoint exactly 0x00100073, and any other system word with funct3 000 is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst | input | 32 | Instruction word to decode |
| illegal | output | 1 | Word is not a supported legal encoding |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rs1_idx | output | 5 | First source register index |
| rs2_idx | output | 5 | Second source register index |
| imm | output | 32 | Extended immediate |
| alu_op | output | 4 | ALU operation code |
| mem_rd | output | 1 | Load access |
| mem_wr | output | 1 | Store access |
| mem_size | output | 2 | Access size code |
| mem_unsigned | output | 1 | Load result is zero-extended |
| br_type | output | 4 | Branch or jump kind |
| sys_class | output | 3 | Ordering or system class |

## Verification
Each immediate form gets words whose immediate is most negative, most positive and made of alternating bits. The alternating patterns show whether bits were scrambled, and the extreme values show whether the sign was extended wrongly. Every funct3 value of each family is applied, legal and illegal alike, so a wrong legality boundary or a shifted operation code shows in one field. Near-miss words are also applied: a system word with a nonzero rd, privileged returns, funct7 variants and foreign low bits. These show whether the decoder rejects whole words or only looks at part of each one.

// File: rtl/idec_pkg.sv
`timescale 1ns/1ps
package idec_pkg;
  localparam int XLEN    = 32;
  localparam int RIDX_W  = 5;
  localparam int SHAMT_W = 5;
  localparam int ALU_W   = 4;
  localparam int BR_W    = 4;
  localparam int SYS_W   = 3;
  localparam int SIZE_W  = 2;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_MISC   = 7'b0001111;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU, ALU_XOR,
    ALU_SRL, ALU_SRA, ALU_OR, ALU_AND, ALU_PASSB
  } alu_op_e;

  typedef enum logic [BR_W-1:0] {
    BR_NONE, BR_EQ, BR_NE, BR_LT, BR_GE, BR_LTU, BR_GEU, BR_JAL, BR_JALR
  } br_e;

  typedef enum logic [SYS_W-1:0] {
    SYS_NONE, SYS_FENCE, SYS_FENCEI, SYS_CSR, SYS_ECALL, SYS_EBREAK
  } sys_e;

  typedef enum logic [2:0] {
    IMM_NONE, IMM_I, IMM_S, IMM_B, IMM_U, IMM_J, IMM_SHAMT, IMM_CSR
  } imm_fmt_e;

  typedef struct packed {
    logic              rd_we;
    logic              use_rs1;
    logic              use_rs2;
    logic              mem_rd;
    logic              mem_wr;
    logic [SIZE_W-1:0] mem_size;
    logic              mem_uns;
    alu_op_e           alu_op;
    br_e               br;
    sys_e              sys;
    imm_fmt_e          fmt;
  } ctrl_t;

  function automatic alu_op_e alu_of_f3(input logic [2:0] f3, input logic alt);
    case (f3)
      3'b000:  return alt ? ALU_SUB : ALU_ADD;
      3'b001:  return ALU_SLL;
      3'b010:  return ALU_SLT;
      3'b011:  return ALU_SLTU;
      3'b100:  return ALU_XOR;
      3'b101:  return alt ? ALU_SRA : ALU_SRL;
      3'b110:  return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction
endpackage

// File: rtl/idec_imm.sv
`timescale 1ns/1ps
module idec_imm
  import idec_pkg::*;
(
  input  logic [XLEN-1:7] ibits,
  input  imm_fmt_e        fmt,
  output logic [XLEN-1:0] imm
);
  localparam int IW = 12;
  localparam int BW = 13;
  localparam int JW = 21;

  logic sgn;
  assign sgn = ibits[XLEN-1];

  always_comb begin
    case (fmt)
      IMM_I:     imm = {{(XLEN-IW){sgn}}, ibits[31:20]};
      IMM_S:     imm = {{(XLEN-IW){sgn}}, ibits[31:25], ibits[11:7]};
      IMM_B:     imm = {{(XLEN-BW){sgn}}, sgn, ibits[7], ibits[30:25], ibits[11:8], 1'b0};
      IMM_U:     imm = {ibits[31:12], {IW{1'b0}}};
      IMM_J:     imm = {{(XLEN-JW){sgn}}, sgn, ibits[19:12], ibits[20], ibits[30:21], 1'b0};
      IMM_SHAMT: imm = {{(XLEN-SHAMT_W){1'b0}}, ibits[20 +: SHAMT_W]};
      IMM_CSR:   imm = {{(XLEN-IW){1'b0}}, ibits[31:20]};
      default:   imm = '0;
    endcase
  end
endmodule

// File: rtl/idec_ctrl.sv
`timescale 1ns/1ps
module idec_ctrl
  import idec_pkg::*;
(
  input  logic [XLEN-1:0] inst,
  output logic            legal,
  output ctrl_t           ctl
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic       ok;
  ctrl_t      c;

  assign opc = inst[6:0];
  assign f3  = inst[14:12];
  assign f7  = inst[31:25];

  always_comb begin
    ok = 1'b0;
    c  = '0;
    case (opc)
      OPC_LUI: begin
        ok = 1'b1; c.rd_we = 1'b1; c.alu_op = ALU_PASSB; c.fmt = IMM_U;
      end
      OPC_AUIPC: begin
        ok = 1'b1; c.rd_we = 1'b1; c.fmt = IMM_U;
      end
      OPC_JAL: begin
        ok = 1'b1; c.rd_we = 1'b1; c.br = BR_JAL; c.fmt = IMM_J;
      end
      OPC_JALR: begin
        ok = (f3 == 3'b000);
        c.rd_we = 1'b1; c.use_rs1 = 1'b1; c.br = BR_JALR; c.fmt = IMM_I;
      end
      OPC_BRANCH: begin
        ok = (f3[2:1] != 2'b01);
        c.use_rs1 = 1'b1; c.use_rs2 = 1'b1; c.fmt = IMM_B;
        case (f3)
          3'b000:  c.br = BR_EQ;
          3'b001:  c.br = BR_NE;
          3'b100:  c.br = BR_LT;
          3'b101:  c.br = BR_GE;
          3'b110:  c.br = BR_LTU;
          default: c.br = BR_GEU;
        endcase
      end
      OPC_LOAD: begin
        ok = (f3[1:0] != 2'b11) && !(f3[2] && f3[1]);
        c.rd_we = 1'b1; c.use_rs1 = 1'b1; c.mem_rd = 1'b1;
        c.mem_size = f3[1:0]; c.mem_uns = f3[2]; c.fmt = IMM_I;
      end
      OPC_STORE: begin
        ok = !f3[2] && (f3[1:0] != 2'b11);
        c.use_rs1 = 1'b1; c.use_rs2 = 1'b1; c.mem_wr = 1'b1;
        c.mem_size = f3[1:0]; c.fmt = IMM_S;
      end
      OPC_OPIMM: begin
        c.rd_we = 1'b1; c.use_rs1 = 1'b1;
        c.alu_op = alu_of_f3(f3, (f3 == 3'b101) && inst[30]);
        if (f3 == 3'b001) begin
          ok = (f7 == F7_BASE); c.fmt = IMM_SHAMT;
        end else if (f3 == 3'b101) begin
          ok = (f7 == F7_BASE) || (f7 == F7_ALT); c.fmt = IMM_SHAMT;
        end else begin
          ok = 1'b1; c.fmt = IMM_I;
        end
      end
      OPC_OP: begin
        c.rd_we = 1'b1; c.use_rs1 = 1'b1; c.use_rs2 = 1'b1;
        c.alu_op = alu_of_f3(f3, f7 == F7_ALT);
        ok = (f7 == F7_BASE) || ((f7 == F7_ALT) && ((f3 == 3'b000) || (f3 == 3'b101)));
      end
      OPC_MISC: begin
        ok    = (f3[2:1] == 2'b00);
        c.sys = f3[0] ? SYS_FENCEI : SYS_FENCE;
      end
      OPC_SYSTEM: begin
        if (f3 == 3'b000) begin
          if (inst[XLEN-1:7] == '0) begin
            ok = 1'b1; c.sys = SYS_ECALL;
          end else if (inst[XLEN-1:7] == {12'h001, 13'h0000}) begin
            ok = 1'b1; c.sys = SYS_EBREAK;
          end
        end else begin
          ok = (f3 != 3'b100);
          c.rd_we = 1'b1; c.use_rs1 = !f3[2]; c.sys = SYS_CSR; c.fmt = IMM_CSR;
        end
      end
      default: ok = 1'b0;
    endcase
    legal = ok;
    ctl   = ok ? c : '0;
  end
endmodule

// File: rtl/inst_decoder.sv
`timescale 1ns/1ps
module inst_decoder
  import idec_pkg::*;
(
  input  logic [XLEN-1:0]   inst,
  output logic              illegal,
  output logic              rd_we,
  output logic [RIDX_W-1:0] rd_idx,
  output logic [RIDX_W-1:0] rs1_idx,
  output logic [RIDX_W-1:0] rs2_idx,
  output logic [XLEN-1:0]   imm,
  output logic [ALU_W-1:0]  alu_op,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [SIZE_W-1:0] mem_size,
  output logic              mem_unsigned,
  output logic [BR_W-1:0]   br_type,
  output logic [SYS_W-1:0]  sys_class
);
  logic  legal;
  ctrl_t ctl;

  idec_ctrl u_ctrl (
    .inst  (inst),
    .legal (legal),
    .ctl   (ctl)
  );

  idec_imm u_imm (
    .ibits (inst[XLEN-1:7]),
    .fmt   (ctl.fmt),
    .imm   (imm)
  );

  assign illegal      = !legal;
  assign rd_we        = ctl.rd_we;
  assign rd_idx       = ctl.rd_we   ? inst[11:7]  : '0;
  assign rs1_idx      = ctl.use_rs1 ? inst[19:15] : '0;
  assign rs2_idx      = ctl.use_rs2 ? inst[24:20] : '0;
  assign alu_op       = ctl.alu_op;
  assign mem_rd       = ctl.mem_rd;
  assign mem_wr       = ctl.mem_wr;
  assign mem_size     = ctl.mem_size;
  assign mem_unsigned = ctl.mem_uns;
  assign br_type      = ctl.br;
  assign sys_class    = ctl.sys;
endmodule

// File: rtl/idec_chk.sv
`timescale 1ns/1ps
module idec_chk
  import idec_pkg::*;
(
  input logic [XLEN-1:0]   inst,
  input logic              illegal,
  input logic              rd_we,
  input logic [RIDX_W-1:0] rd_idx,
  input logic [RIDX_W-1:0] rs1_idx,
  input logic [RIDX_W-1:0] rs2_idx,
  input logic [XLEN-1:0]   imm,
  input logic [ALU_W-1:0]  alu_op,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [SIZE_W-1:0] mem_size,
  input logic              mem_unsigned,
  input logic [BR_W-1:0]   br_type,
  input logic [SYS_W-1:0]  sys_class
);
  always_comb begin
    if (!$isunknown(inst)) begin
      p_low_bits_r2: assert (inst[1:0] == 2'b11 || illegal);
      p_inert_r3: assert (!illegal || (!rd_we && !mem_rd && !mem_wr && br_type == '0 &&
                                       sys_class == '0 && rd_idx == '0 && rs1_idx == '0 &&
                                       rs2_idx == '0 && imm == '0));
      p_even_target_r4: assert (br_type == '0 || br_type == BR_JALR || imm[0] == 1'b0);
      p_rd_gated_r6: assert (rd_idx == '0 || rd_we);
      p_alu_range_r7: assert (alu_op <= ALU_PASSB);
      p_mem_excl_r8: assert (!(mem_rd && mem_wr) && (!(mem_rd || mem_wr) || mem_size != 2'b11) &&
                             (!mem_unsigned || mem_rd));
      p_ecall_r12: assert (inst != 32'h0000_0073 || sys_class == SYS_ECALL);
      p_sys_quiet_r12: assert (sys_class == '0 || (!mem_rd && !mem_wr && br_type == '0));
    end
  end
endmodule

bind inst_decoder idec_chk u_chk (.*);

// File: tb/inst_decoder_tb.sv
`timescale 1ns/1ps
module inst_decoder_tb;
  import idec_pkg::*;

  typedef struct packed {
    logic        ill;
    logic        we;
    logic [4:0]  rd;
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [31:0] imm;
    logic [3:0]  alu;
    logic        mrd;
    logic        mwr;
    logic [1:0]  msz;
    logic        muns;
    logic [3:0]  br;
    logic [2:0]  sys;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] inst = 32'h0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic        illegal, rd_we, mem_rd, mem_wr, mem_unsigned;
  logic [4:0]  rd_idx, rs1_idx, rs2_idx;
  logic [31:0] imm;
  logic [3:0]  alu_op, br_type;
  logic [1:0]  mem_size;
  logic [2:0]  sys_class;

  always #4 clk = ~clk;

  inst_decoder u_dut (
    .inst(inst), .illegal(illegal), .rd_we(rd_we), .rd_idx(rd_idx),
    .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .imm(imm), .alu_op(alu_op),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_size(mem_size),
    .mem_unsigned(mem_unsigned), .br_type(br_type), .sys_class(sys_class)
  );

  function automatic exp_t mk(input logic ill, input logic we, input logic [4:0] rd,
                              input logic [4:0] rs1, input logic [4:0] rs2,
                              input logic [31:0] im, input logic [3:0] alu,
                              input logic mrd, input logic mwr, input logic [1:0] msz,
                              input logic muns, input logic [3:0] br, input logic [2:0] sys);
    exp_t e;
    e.ill = ill; e.we = we; e.rd = rd; e.rs1 = rs1; e.rs2 = rs2; e.imm = im;
    e.alu = alu; e.mrd = mrd; e.mwr = mwr; e.msz = msz; e.muns = muns;
    e.br = br; e.sys = sys;
    return e;
  endfunction

  function automatic exp_t ill_e();
    return mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endfunction

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] im, input logic [4:0] rs1,
      input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
    return {im, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] enc_s(input logic [11:0] im, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3, input logic [6:0] op);
    return {im[11:5], rs2, rs1, f3, im[4:0], op};
  endfunction
  function automatic logic [31:0] enc_b(input logic [12:0] im, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3);
    return {im[12], im[10:5], rs2, rs1, f3, im[4:1], im[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_u(input logic [19:0] im, input logic [4:0] rd,
      input logic [6:0] op);
    return {im, rd, op};
  endfunction
  function automatic logic [31:0] enc_j(input logic [20:0] im, input logic [4:0] rd);
    return {im[20], im[10:1], im[11], im[19:12], rd, 7'b1101111};
  endfunction

  function automatic logic [3:0] exp_alu(input int f3, input bit alt);
    case (f3)
      0: return alt ? 4'd1 : 4'd0;
      1: return 4'd2;
      2: return 4'd3;
      3: return 4'd4;
      4: return 4'd5;
      5: return alt ? 4'd7 : 4'd6;
      6: return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (inst %h)", req, what, got, exp, inst);
    end
  endtask

  task automatic compare(input string req, input exp_t e);
    chk(req, "illegal",  32'(illegal),      32'(e.ill));
    chk(req, "rd_we",    32'(rd_we),        32'(e.we));
    chk(req, "rd_idx",   32'(rd_idx),       32'(e.rd));
    chk(req, "rs1_idx",  32'(rs1_idx),      32'(e.rs1));
    chk(req, "rs2_idx",  32'(rs2_idx),      32'(e.rs2));
    chk(req, "imm",      imm,               e.imm);
    chk(req, "alu_op",   32'(alu_op),       32'(e.alu));
    chk(req, "mem_rd",   32'(mem_rd),       32'(e.mrd));
    chk(req, "mem_wr",   32'(mem_wr),       32'(e.mwr));
    chk(req, "mem_size", 32'(mem_size),     32'(e.msz));
    chk(req, "mem_uns",  32'(mem_unsigned), 32'(e.muns));
    chk(req, "br_type",  32'(br_type),      32'(e.br));
    chk(req, "sys",      32'(sys_class),    32'(e.sys));
  endtask

  task automatic apply(input string req, input logic [31:0] w, input exp_t e);
    @(posedge clk);
    inst = w;
    #2;
    compare(req, e);
  endtask

  // R2 R3: all-zero word during reset
  task automatic t_reset();
    inst = 32'h0;
    #3;
    compare("R2_R3_reset", ill_e());
  endtask

  // R1: outputs follow inst inside one clock phase
  task automatic t_comb();
    @(negedge clk);
    inst = enc_u(20'h12345, 5'd4, 7'b0110111);
    #1;
    chk("R1", "imm", imm, 32'h12345000);
    inst = 32'h0000_0001;
    #1;
    chk("R1", "illegal", 32'(illegal), 32'd1);
    chk("R1", "imm", imm, 32'h0);
  endtask

  // R4 R7 R11: upper immediates
  task automatic t_upper();
    apply("R4_R7_lui", enc_u(20'hABCDE, 5'd5, 7'b0110111),
          mk(0, 1, 5, 0, 0, 32'hABCDE000, 10, 0, 0, 0, 0, 0, 0));
    apply("R4_R11_auipc", enc_u(20'h80000, 5'd7, 7'b0010111),
          mk(0, 1, 7, 0, 0, 32'h80000000, 0, 0, 0, 0, 0, 0, 0));
  endtask

  // R4 R9 R10: jumps
  task automatic t_jump();
    apply("R4_R9_jal_neg", enc_j(21'h1FFFF8, 5'd1),
          mk(0, 1, 1, 0, 0, 32'hFFFFFFF8, 0, 0, 0, 0, 0, 7, 0));
    apply("R4_jal_max", enc_j(21'h0FFFFE, 5'd1),
          mk(0, 1, 1, 0, 0, 32'h000FFFFE, 0, 0, 0, 0, 0, 7, 0));
    apply("R4_jal_alt", enc_j(21'h0AAAAA, 5'd0),
          mk(0, 1, 0, 0, 0, 32'h000AAAAA, 0, 0, 0, 0, 0, 7, 0));
    apply("R9_jalr_odd", enc_i(12'hFFF, 5'd3, 3'b000, 5'd2, 7'b1100111),
          mk(0, 1, 2, 3, 0, 32'hFFFFFFFF, 0, 0, 0, 0, 0, 8, 0));
    apply("R10_jalr_f3", enc_i(12'h004, 5'd3, 3'b001, 5'd2, 7'b1100111), ill_e());
  endtask

  // R9 R10 R4: conditional branches, all funct3
  task automatic t_branch();
    for (int f = 0; f < 8; f++) begin
      logic [3:0] b;
      case (f)
        0: b = 1; 1: b = 2; 4: b = 3; 5: b = 4; 6: b = 5; default: b = 6;
      endcase
      if (f == 2 || f == 3)
        apply("R10_branch_f3", enc_b(13'h1000, 5'd7, 5'd6, 3'(f)), ill_e());
      else
        apply("R9_R4_branch", enc_b(13'h1000, 5'd7, 5'd6, 3'(f)),
              mk(0, 0, 0, 6, 7, 32'hFFFFF000, 0, 0, 0, 0, 0, b, 0));
    end
    apply("R4_branch_max", enc_b(13'h0FFE, 5'd1, 5'd2, 3'b000),
          mk(0, 0, 0, 2, 1, 32'h00000FFE, 0, 0, 0, 0, 0, 1, 0));
  endtask

  // R8 R10 R6: loads and stores, all funct3
  task automatic t_mem();
    for (int f = 0; f < 8; f++) begin
      logic [2:0] g;
      g = 3'(f);
      if (f == 3 || f == 6 || f == 7)
        apply("R10_load_f3", enc_i(12'h123, 5'd10, g, 5'd9, 7'b0000011), ill_e());
      else
        apply("R8_load", enc_i(12'h123, 5'd10, g, 5'd9, 7'b0000011),
              mk(0, 1, 9, 10, 0, 32'h123, 0, 1, 0, g[1:0], g[2], 0, 0));
      if (f >= 3)
        apply("R10_store_f3", enc_s(12'hFFF, 5'd12, 5'd11, g, 7'b0100011), ill_e());
      else
        apply("R8_R4_store", enc_s(12'hFFF, 5'd12, 5'd11, g, 7'b0100011),
              mk(0, 0, 0, 11, 12, 32'hFFFFFFFF, 0, 0, 1, g[1:0], 0, 0, 0));
    end
    apply("R4_store_mix", enc_s(12'h7E5, 5'd3, 5'd4, 3'b010, 7'b0100011),
          mk(0, 0, 0, 4, 3, 32'h000007E5, 0, 0, 1, 2, 0, 0, 0));
  endtask

  // R5 R7 R10: register-immediate arithmetic
  task automatic t_opimm();
    apply("R4_R7_addi", enc_i(12'h800, 5'd2, 3'b000, 5'd1, 7'b0010011),
          mk(0, 1, 1, 2, 0, 32'hFFFFF800, 0, 0, 0, 0, 0, 0, 0));
    apply("R7_slti", enc_i(12'h005, 5'd2, 3'b010, 5'd1, 7'b0010011),
          mk(0, 1, 1, 2, 0, 32'h5, 3, 0, 0, 0, 0, 0, 0));
    apply("R7_sltiu", enc_i(12'h005, 5'd2, 3'b011, 5'd1, 7'b0010011),
          mk(0, 1, 1, 2, 0, 32'h5, 4, 0, 0, 0, 0, 0, 0));
    apply("R7_xori", enc_i(12'hAAA, 5'd2, 3'b100, 5'd1, 7'b0010011),
          mk(0, 1, 1, 2, 0, 32'hFFFFFAAA, 5, 0, 0, 0, 0, 0, 0));
    apply("R7_ori", enc_i(12'h555, 5'd2, 3'b110, 5'd1, 7'b0010011),
          mk(0, 1, 1, 2, 0, 32'h555, 8, 0, 0, 0, 0, 0, 0));
    apply("R7_andi", enc_i(12'h7FF, 5'd2, 3'b111, 5'd1, 7'b0010011),
          mk(0, 1, 1, 2, 0, 32'h7FF, 9, 0, 0, 0, 0, 0, 0));
    apply("R5_slli", enc_i({7'b0000000, 5'd31}, 5'd4, 3'b001, 5'd3, 7'b0010011),
          mk(0, 1, 3, 4, 0, 32'd31, 2, 0, 0, 0, 0, 0, 0));
    apply("R5_srli", enc_i({7'b0000000, 5'd1}, 5'd4, 3'b101, 5'd3, 7'b0010011),
          mk(0, 1, 3, 4, 0, 32'd1, 6, 0, 0, 0, 0, 0, 0));
    apply("R5_srai", enc_i({7'b0100000, 5'd7}, 5'd4, 3'b101, 5'd3, 7'b0010011),
          mk(0, 1, 3, 4, 0, 32'd7, 7, 0, 0, 0, 0, 0, 0));
    apply("R10_slli_f7", enc_i({7'b0100000, 5'd7}, 5'd4, 3'b001, 5'd3, 7'b0010011), ill_e());
    apply("R10_srli_f7", enc_i({7'b0000001, 5'd7}, 5'd4, 3'b101, 5'd3, 7'b0010011), ill_e());
  endtask

  // R7 R6 R10: register-register arithmetic
  task automatic t_op();
    for (int f = 0; f < 8; f++) begin
      apply("R7_R6_op", enc_r(7'b0000000, 5'd15, 5'd14, 3'(f), 5'd13, 7'b0110011),
            mk(0, 1, 13, 14, 15, 0, exp_alu(f, 0), 0, 0, 0, 0, 0, 0));
      if (f == 0 || f == 5)
        apply("R7_op_alt", enc_r(7'b0100000, 5'd15, 5'd14, 3'(f), 5'd13, 7'b0110011),
              mk(0, 1, 13, 14, 15, 0, exp_alu(f, 1), 0, 0, 0, 0, 0, 0));
      else
        apply("R10_op_alt", enc_r(7'b0100000, 5'd15, 5'd14, 3'(f), 5'd13, 7'b0110011), ill_e());
    end
    apply("R10_op_f7", enc_r(7'b0000001, 5'd15, 5'd14, 3'b000, 5'd13, 7'b0110011), ill_e());
  endtask

  // R12 R5 R10: ordering and system words
  task automatic t_system();
    apply("R12_fence", 32'h0FF0000F, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    apply("R12_fencei", 32'h0000100F, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2));
    apply("R10_misc_f3", 32'h0000200F, ill_e());
    apply("R12_ecall", 32'h00000073, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4));
    apply("R12_ebreak", 32'h00100073, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5));
    apply("R12_ecall_rd", 32'h000000F3, ill_e());
    apply("R12_mret", 32'h30200073, ill_e());
    apply("R12_wfi", 32'h10500073, ill_e());
    apply("R12_R5_csrrw", enc_i(12'h305, 5'd4, 3'b001, 5'd3, 7'b1110011),
          mk(0, 1, 3, 4, 0, 32'h305, 0, 0, 0, 0, 0, 0, 3));
    apply("R5_R6_csrrsi", enc_i(12'hFFF, 5'd5, 3'b110, 5'd3, 7'b1110011),
          mk(0, 1, 3, 0, 0, 32'h00000FFF, 0, 0, 0, 0, 0, 0, 3));
    apply("R10_sys_f3", enc_i(12'h305, 5'd4, 3'b100, 5'd3, 7'b1110011), ill_e());
  endtask

  // R2 R3: foreign low bits and unknown opcodes
  task automatic t_illegal();
    apply("R2_low_bits", 32'h00004501, ill_e());
    apply("R2_low_bits_lui", 32'hABCDE2B4, ill_e());
    apply("R2_opcode", 32'h0000002B, ill_e());
    apply("R2_R3_ones", 32'hFFFFFFFF, ill_e());
    apply("R2_R3_zero", 32'h00000000, ill_e());
  endtask

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_comb();
    t_upper();
    t_jump();
    t_branch();
    t_mem();
    t_opimm();
    t_op();
    t_system();
    t_illegal();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule